// File: doc/BRIEF.md
# Free-Running Idle Window Timer

This block is a timebase that keeps real time while the rest of a device sleeps. A 16-bit counter moves forward by one on every instruction cycle. It never stops and is never reloaded, in normal operation and in the low-power idle state alike. The window does not come from a count that is loaded and then decremented. The block watches one tap of the counter, picked by a small select register. Each time that tap flips, one window has passed.

Every flip of the chosen tap does three things. It sets a sticky pending flag. It raises an interrupt request if the interrupt is enabled. It sends a one-cycle expiry strobe to the power-mode sequencer, which uses the strobe to leave the idle state. The sequencer is not part of this block. Software writes the window code and the interrupt enable through a small write port. Software also clears the pending flag with a dedicated strobe.

Top module: `idle_window_timer`

## Requirements
- R1: The counter advances by one only on clock edges where `cyc_en` is high. It holds otherwise. Neither a window change nor the pending flag ever reloads or stops it.
- R2: Window code k (0 to 4) selects a window of 4096·2^k enabled cycles. `expiry` is high for the one clock cycle that follows the enabled edge at which the number of enabled cycles since reset becomes a nonzero multiple of the window. This holds across the 16-bit wrap.
- R3: Window codes 5, 6 and 7 behave exactly like code 0, a 4096-cycle window.
- R4: The expiry strobe and the setting of the pending flag happen whether the interrupt enable is 0 or 1.
- R5: `pend` rises together with `expiry` and stays high until a cycle with `pend_clr` high. If a clear and a window flip fall on the same edge, the flip wins and `pend` stays high.
- R6: `irq` is high exactly when `pend` is high and the stored interrupt enable is 1.
- R7: Reset sets the window code to 0 (4096 cycles) and the interrupt enable to 0. After reset `pend`, `irq` and `expiry` are low, and the cycle count restarts from zero.
- R8: The 65536-cycle window (code 4) fires when the counter wraps from all ones to zero. Changing the window code produces no strobe outside the new window's boundaries.
- R9: `expiry` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_en | input | 1 | Instruction-cycle enable; the counter steps on edges where it is high |
| cfg_we | input | 1 | Write strobe for the window code and the interrupt enable |
| cfg_sel | input | 3 | Window code written on `cfg_we` |
| cfg_ien | input | 1 | Interrupt enable written on `cfg_we` |
| pend_clr | input | 1 | Software clear of the pending flag |
| pend | output | 1 | Sticky pending flag |
| irq | output | 1 | Interrupt request, pending and enabled |
| expiry | output | 1 | One-cycle window-expiry strobe to the power-mode sequencer |

## Verification
The hardest case to reach from the ports is a software clear that lands on the exact edge where the chosen tap flips. The ports give no view of the counter. The bench therefore keeps its own count of enabled cycles from reset. When that count shows that the next enabled edge completes a window, the bench raises `pend_clr` for just that edge. The widest window fires only when the counter wraps, tens of thousands of cycles in. The bench gets there by switching to code 4 after the shorter windows have used up part of the count. It then compares every strobe against its own cycle count, so any stray pulse caused by the code change is caught.

// File: rtl/iwt_pkg.sv
package iwt_pkg;

  // Window code to tap index; codes beyond the last window fall back to 0.
  function automatic int unsigned sel_to_idx(input logic [2:0] code,
                                             input int unsigned num_win);
    if (int'(code) < int'(num_win)) return int'(code);
    return 0;
  endfunction

  // Number of counter bits below the tap for window index idx.
  function automatic int unsigned tap_low_bits(input int unsigned idx,
                                               input int unsigned cnt_w,
                                               input int unsigned num_win);
    return cnt_w - num_win + 1 + idx;
  endfunction

endpackage

// File: rtl/iwt_counter.sv
module iwt_counter
  import iwt_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_WIN = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_en,
  output logic [CNT_W-1:0]   cnt,
  output logic [NUM_WIN-1:0] tap_toggle
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cyc_en) cnt_q <= cnt_q + 1'b1;
  end

  // A tap flips on the enabled edge where every bit below it is one.
  // The widest window watches all bits, i.e. the carry out of the top bit.
  for (genvar k = 0; k < NUM_WIN; k++) begin : g_tap
    localparam int unsigned LB = tap_low_bits(k, CNT_W, NUM_WIN);
    assign tap_toggle[k] = cyc_en & (&cnt_q[LB-1:0]);
  end

  assign cnt = cnt_q;

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> $stable(cnt_q));

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/iwt_window_sel.sv
module iwt_window_sel
  import iwt_pkg::*;
#(
  parameter int unsigned NUM_WIN = 5,
  parameter int unsigned SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic               cfg_ien,
  input  logic [NUM_WIN-1:0] tap_toggle,
  output logic               ien,
  output logic               hit
);

  logic [SEL_W-1:0] sel_q;
  logic             ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      ien_q <= 1'b0;
    end else if (cfg_we) begin
      sel_q <= cfg_sel;
      ien_q <= cfg_ien;
    end
  end

  // The toggle vector is decoded per bit, so changing the code cannot make a false edge.
  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < int'(NUM_WIN); k++)
      if (k == int'(sel_to_idx(3'(sel_q), NUM_WIN))) hit = tap_toggle[k];
  end

  assign ien = ien_q;

  // R3
  sel_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel_q) >= int'(NUM_WIN)) |-> (hit == tap_toggle[0]));

endmodule

// File: rtl/iwt_pending.sv
module iwt_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr,
  input  logic ien,
  output logic pend,
  output logic irq
);

  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (set_ev) pend_q <= 1'b1;
    else if (clr)    pend_q <= 1'b0;
  end

  assign pend = pend_q;
  assign irq  = pend_q & ien;

  // R4
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> pend_q);

  // R5
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr) |=> pend_q);

  // R5
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_ev) |=> !pend_q);

endmodule

// File: rtl/idle_window_timer.sv
module idle_window_timer
  import iwt_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_WIN = 5,
  parameter int unsigned SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             cfg_ien,
  input  logic             pend_clr,
  output logic             pend,
  output logic             irq,
  output logic             expiry
);

  localparam int unsigned LOW_W = tap_low_bits(0, CNT_W, NUM_WIN);

  logic [CNT_W-1:0]   cnt;
  logic [NUM_WIN-1:0] tap_toggle;
  logic               win_hit;
  logic               ien;
  logic               expiry_q;

  iwt_counter #(.CNT_W(CNT_W), .NUM_WIN(NUM_WIN)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en),
    .cnt(cnt), .tap_toggle(tap_toggle)
  );

  iwt_window_sel #(.NUM_WIN(NUM_WIN), .SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_ien(cfg_ien), .tap_toggle(tap_toggle), .ien(ien), .hit(win_hit)
  );

  iwt_pending u_pend (
    .clk(clk), .rst_n(rst_n), .set_ev(win_hit), .clr(pend_clr),
    .ien(ien), .pend(pend), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) expiry_q <= 1'b0;
    else        expiry_q <= win_hit;
  end

  assign expiry = expiry_q;

  // R2
  expiry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expiry |-> (cnt[LOW_W-1:0] == '0));

  // R9
  expiry_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expiry |=> !expiry);

  // R5
  expiry_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expiry |-> pend);

  // R6
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend);

endmodule

// File: tb/tb_idle_window_timer.sv
module tb_idle_window_timer;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 195000;

  logic clk = 1'b0, rst_n = 1'b0, cyc_en = 1'b1, cfg_we = 1'b0, cfg_ien = 1'b0, pend_clr = 1'b0;
  logic [2:0] cfg_sel = 3'd0;
  logic pend, irq, expiry;

  int checks = 0, errors = 0;
  int unsigned m_cnt;
  logic [2:0] m_sel;
  logic m_exp;
  bit mon_on = 1'b0;
  string mon_req = "R2";

  idle_window_timer dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_ien(cfg_ien), .pend_clr(pend_clr), .pend(pend), .irq(irq), .expiry(expiry)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int unsigned b_win(input logic [2:0] c);
    if (c <= 3'd4) return 32'd4096 << c;
    return 32'd4096;
  endfunction

  // Bench timebase: enabled cycles since reset and the strobe they imply.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_sel <= 3'd0; m_exp <= 1'b0;
    end else begin
      if (cyc_en) m_cnt <= m_cnt + 1;
      m_exp <= cyc_en && (((m_cnt + 1) % b_win(m_sel)) == 0);
      if (cfg_we) m_sel <= cfg_sel;
    end
  end

  always @(negedge clk) begin
    if (rst_n && mon_on && (expiry || m_exp)) begin
      checks++;
      if (expiry !== m_exp) begin
        errors++;
        $display("FAIL %s expiry at cycle %0d: actual %b expected %b", mon_req, m_cnt, expiry, m_exp);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_exp(input string req, input int maxc);
    int n = 0;
    do begin @(negedge clk); n++; end while (!expiry && n < maxc);
    chk(req, expiry, 1'b1);
  endtask

  task automatic cfg_write(input logic [2:0] code, input logic en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = code; cfg_ien = en;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_pend();
    @(negedge clk); pend_clr = 1'b1;
    @(negedge clk); pend_clr = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R7 pend in reset", pend, 1'b0);
    chk("R7 irq in reset", irq, 1'b0);
    chk("R7 expiry in reset", expiry, 1'b0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    mon_req = "R7 default window";
  endtask

  task automatic t_default();
    wait_exp("R7 first window", 5000);
    chk_int("R7 default window length", int'(m_cnt), 4096);
    chk("R4 pend set with irq disabled", pend, 1'b1);
    chk("R6 irq stays low when disabled", irq, 1'b0);
    @(negedge clk);
    chk("R9 strobe one cycle", expiry, 1'b0);
  endtask

  task automatic t_hold_clear();
    repeat (100) @(negedge clk);
    chk("R5 pend holds", pend, 1'b1);
    clear_pend();
    chk("R5 pend cleared", pend, 1'b0);
  endtask

  task automatic t_irq();
    cfg_write(3'd0, 1'b1);
    mon_req = "R2 code 0";
    wait_exp("R2 code 0 expiry", 5000);
    chk("R6 irq raised", irq, 1'b1);
    clear_pend();
    chk("R6 irq dropped after clear", irq, 1'b0);
  endtask

  task automatic t_set_wins();
    int n = 0;
    while ((((m_cnt + 1) % b_win(m_sel)) != 0) && n < 10000) begin
      @(negedge clk); n++;
    end
    pend_clr = 1'b1;
    @(negedge clk);
    pend_clr = 1'b0;
    chk("R5 set beats clear: expiry", expiry, 1'b1);
    chk("R5 set beats clear: pend", pend, 1'b1);
    clear_pend();
  endtask

  task automatic t_measure(input logic [2:0] code, input string req);
    int n = 0;
    cfg_write(code, 1'b0);
    mon_req = req;
    wait_exp(req, int'(b_win(code)) + 10);
    do begin @(negedge clk); n++; end while (!expiry && n < int'(b_win(code)) + 10);
    chk_int(req, n, int'(b_win(code)));
    chk(req, irq, 1'b0);
  endtask

  task automatic t_gated();
    bit seen = 1'b0;
    mon_req = "R1 gated";
    cfg_write(3'd0, 1'b0);
    for (int i = 0; i < 20000 && !seen; i++) begin
      @(negedge clk);
      if (expiry) seen = 1'b1;
      cyc_en = ~cyc_en;
    end
    cyc_en = 1'b1;
    chk("R1 gated expiry seen", seen, 1'b1);
  endtask

  task automatic t_wide();
    mon_req = "R8 wrap";
    cfg_write(3'd4, 1'b1);
    wait_exp("R8 wrap expiry", 70000);
    chk_int("R8 wrap alignment", int'(m_cnt % 65536), 0);
    chk("R8 irq on wrap", irq, 1'b1);
  endtask

  initial begin
    t_reset();
    t_default();
    t_hold_clear();
    t_irq();
    t_set_wins();
    t_measure(3'd1, "R2 code 1");
    t_measure(3'd5, "R3 code 5");
    t_measure(3'd7, "R3 code 7");
    t_gated();
    t_wide();
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule